// File: doc/BRIEF.md
# Nested-Call Windowed Register File

This block is a register file whose physical storage is cut into equal, non-overlapping windows. Software addresses only a small logical space, the registers of the current window. Each nested procedure level gets a private window, so a callee can use its registers freely without saving the caller's values. A call pulse moves the logical view one window deeper. A return pulse gives up the callee's window and brings the caller's registers back into view.

There are two combinational read ports and one synchronous write port, all addressed by a logical index inside the current window. The physical address is the nesting level joined above the logical index, so window `k` holds physical registers `k*WIN_REGS` to `k*WIN_REGS+WIN_REGS-1`. The level counter also serves as the window pointer. When a call would need more windows than the bank has, or a return has no caller to go back to, the block raises a one-cycle overflow or underflow flag and changes no state. Spilling windows to memory is left to whatever logic reacts to these flags. Control and data pins are plain level signals without a handshake. The file always accepts a write and a pulse, so there is no back-pressure.

With the defaults there are 8 windows of 8 registers of 32 bits each, 64 physical registers in total, and up to eight live procedure levels (the root plus seven nested calls).

Top module: `nested_window_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every physical register to zero, sets the level to 0 and drops both flags.
- R2: Each read port returns, in the same cycle and without a clock edge, the physical register at address `level*WIN_REGS + index` for its logical index.
- R3: A cycle with `call_i`=1, `ret_i`=0 and level below `NUM_WIN-1` raises the level by one at that clock edge, and from then on the logical indices reach the next window.
- R4: A cycle with `ret_i`=1, `call_i`=0 and level above 0 lowers the level by one at that edge, and the caller's registers read back with the values they held before the call.
- R5: A write (`wr_en_i`=1) updates, at the clock edge, the register in the window that was current during that cycle, even when a call or return is pulsed in the same cycle.
- R6: A call at level `NUM_WIN-1` sets `ovf_o` in the following cycle only, leaves the level unchanged and overwrites no window.
- R7: A return at level 0 sets `unf_o` in the following cycle only and leaves the level unchanged.
- R8: `call_i` and `ret_i` high in the same cycle is a no-op: the level stays and neither flag is set.
- R9: A write changes only the one addressed register. Every other window keeps its contents.
- R10: `level_o` shows, in plain binary, the number of calls currently nested (0 at the root).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Call pulse: enter a fresh window |
| ret_i | input | 1 | Return pulse: go back to the caller's window |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | $clog2(WIN_REGS) | Logical write index |
| wr_data_i | input | DATA_W | Write data |
| rd_a_idx_i | input | $clog2(WIN_REGS) | Logical index, read port A |
| rd_a_data_o | output | DATA_W | Read data, port A (combinational) |
| rd_b_idx_i | input | $clog2(WIN_REGS) | Logical index, read port B |
| rd_b_data_o | output | DATA_W | Read data, port B (combinational) |
| level_o | output | $clog2(NUM_WIN) | Current nesting level and window pointer |
| ovf_o | output | 1 | One-cycle flag: call refused, the windows are exhausted |
| unf_o | output | 1 | One-cycle flag: return refused at the root |

## Verification
Read data is due in the same cycle as the index that selects it. Written data, a new level and either flag are due exactly one rising edge after the cycle that carries the stimulus, and a flag must be gone one edge later. The bench drives all inputs on the falling edge. It sweeps both read indices and checks the read data a fraction of a nanosecond later, before the next rising edge, and it checks level and flags 1 ns after the rising edge that should have updated them. A reference array and a level model in the bench, filled with arithmetic patterns per window and register, give every expected value.

// File: rtl/nwrf_pkg.sv
`timescale 1ns/1ps
package nwrf_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLASH = 2'd3
  } win_op_e;

  function automatic win_op_e decode_op(input logic call, input logic ret);
    win_op_e op;
    case ({call, ret})
      2'b10:   op = OP_PUSH;
      2'b01:   op = OP_POP;
      2'b11:   op = OP_CLASH;
      default: op = OP_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/nwrf_level_ctrl.sv
`timescale 1ns/1ps
module nwrf_level_ctrl
  import nwrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int LVL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o,
  output logic             unf_o
);

  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(NUM_WIN - 1);

  win_op_e          op;
  logic [LVL_W-1:0] level_q;
  logic             ovf_q;
  logic             unf_q;

  assign op = decode_op(call_i, ret_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      case (op)
        OP_PUSH: begin
          if (level_q == LVL_TOP) ovf_q <= 1'b1;
          else                    level_q <= level_q + 1'b1;
        end
        OP_POP: begin
          if (level_q == '0) unf_q <= 1'b1;
          else               level_q <= level_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign level_o = level_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  AST_CALL_DEEPENS: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && level_q != LVL_TOP) |=> level_q == $past(level_q) + 1'b1); // R3

  AST_RET_RISES: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && level_q != '0) |=> level_q == $past(level_q) - 1'b1); // R4

  AST_OVF_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && level_q == LVL_TOP) |=> (ovf_q && level_q == LVL_TOP)); // R6

  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !(call_i && !ret_i)) |=> !ovf_q); // R6

  AST_UNF_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && level_q == '0) |=> (unf_q && level_q == '0)); // R7

  AST_CLASH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> ($stable(level_q) && !ovf_q && !unf_q)); // R8

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_TOP); // R10

endmodule

// File: rtl/nwrf_bank.sv
`timescale 1ns/1ps
module nwrf_bank #(
  parameter int DATA_W   = 32,
  parameter int WIN_REGS = 8,
  parameter int NUM_WIN  = 8,
  parameter int LVL_W    = 3,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o
);

  localparam int PHYS = NUM_WIN * WIN_REGS;
  localparam int PA_W = LVL_W + IDX_W;

  logic [DATA_W-1:0] cells [PHYS];
  logic [PA_W-1:0]   wr_pa;
  logic [PA_W-1:0]   rd_a_pa;
  logic [PA_W-1:0]   rd_b_pa;

  assign wr_pa   = {level_i, wr_idx_i};
  assign rd_a_pa = {level_i, rd_a_idx_i};
  assign rd_b_pa = {level_i, rd_b_idx_i};

  for (genvar g = 0; g < PHYS; g++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                 q <= '0;
      else if (wr_en_i && wr_pa == PA_W'(g))   q <= wr_data_i;
    end
    assign cells[g] = q;
  end

  assign rd_a_data_o = cells[rd_a_pa];
  assign rd_b_data_o = cells[rd_b_pa];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> cells[$past(wr_pa)] == $past(wr_data_i)); // R5

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o)); // R2

endmodule

// File: rtl/nested_window_regfile.sv
`timescale 1ns/1ps
module nested_window_regfile #(
  parameter int DATA_W   = 32,
  parameter int WIN_REGS = 8,
  parameter int NUM_WIN  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        call_i,
  input  logic                        ret_i,
  input  logic                        wr_en_i,
  input  logic [$clog2(WIN_REGS)-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [$clog2(WIN_REGS)-1:0] rd_a_idx_i,
  output logic [DATA_W-1:0]           rd_a_data_o,
  input  logic [$clog2(WIN_REGS)-1:0] rd_b_idx_i,
  output logic [DATA_W-1:0]           rd_b_data_o,
  output logic [$clog2(NUM_WIN)-1:0]  level_o,
  output logic                        ovf_o,
  output logic                        unf_o
);

  localparam int IDX_W = $clog2(WIN_REGS);
  localparam int LVL_W = $clog2(NUM_WIN);

  logic [LVL_W-1:0] level;

  nwrf_level_ctrl #(
    .NUM_WIN (NUM_WIN),
    .LVL_W   (LVL_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .level_o (level),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  nwrf_bank #(
    .DATA_W   (DATA_W),
    .WIN_REGS (WIN_REGS),
    .NUM_WIN  (NUM_WIN),
    .LVL_W    (LVL_W),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .level_i     (level),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_idx_i  (rd_b_idx_i),
    .rd_b_data_o (rd_b_data_o)
  );

  assign level_o = level;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o)); // R6

endmodule

// File: tb/test_nested_window_regfile.sv
`timescale 1ns/1ps
module test_nested_window_regfile;

  localparam int DW = 32;
  localparam int WR = 8;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_i = 1'b0, ret_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]    wr_idx_i = '0, rd_a_idx_i = '0, rd_b_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_a_data_o, rd_b_data_o;
  logic [2:0]    level_o;
  logic          ovf_o, unf_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] mem [NW*WR];
  int            mlevel = 0;
  logic          e_ovf = 1'b0, e_unf = 1'b0;

  always #4 clk = ~clk;

  nested_window_regfile #(.DATA_W(DW), .WIN_REGS(WR), .NUM_WIN(NW)) i_nested_window_regfile (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
    .level_o(level_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic logic [DW-1:0] pat(input int l, input int r);
    return 32'h5A000000 + DW'(l * 256 + r * 17 + 1);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sweep every logical index on both ports, after a falling edge
  task automatic chk_window(input string req);
    @(negedge clk);
    call_i = 0; ret_i = 0; wr_en_i = 0;
    for (int i = 0; i < WR; i++) begin
      rd_a_idx_i = 3'(i);
      rd_b_idx_i = 3'(WR - 1 - i);
      #0.25;
      chk(req, rd_a_data_o, mem[mlevel*WR + i]);
      chk(req, rd_b_data_o, mem[mlevel*WR + (WR - 1 - i)]);
    end
  endtask

  // one cycle of stimulus, model update at the edge, checks after it
  task automatic step(input logic c, input logic r, input logic we,
                      input int wi, input logic [DW-1:0] wd, input string req);
    @(negedge clk);
    call_i = c; ret_i = r; wr_en_i = we; wr_idx_i = 3'(wi); wr_data_i = wd;
    @(posedge clk);
    e_ovf = 0; e_unf = 0;
    if (we) mem[mlevel*WR + wi] = wd;
    if (c && !r) begin
      if (mlevel == NW - 1) e_ovf = 1; else mlevel++;
    end else if (r && !c) begin
      if (mlevel == 0) e_unf = 1; else mlevel--;
    end
    #1;
    chk({req, " level R10"}, DW'(level_o), DW'(mlevel));
    chk({req, " ovf R6"}, DW'(ovf_o), DW'(e_ovf));
    chk({req, " unf R7"}, DW'(unf_o), DW'(e_unf));
  endtask

  initial begin
    for (int k = 0; k < NW*WR; k++) mem[k] = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 level", DW'(level_o), 0);
    chk("R1 ovf", DW'(ovf_o), 0);
    chk("R1 unf", DW'(unf_o), 0);
    chk_window("R1 cleared");

    // fill each window; the last write of each window rides on a call (R5, R3)
    for (int l = 0; l < NW; l++) begin
      chk_window("R3 fresh window");
      for (int r = 0; r < WR; r++)
        step(r == WR - 1, 1'b0, 1'b1, r, pat(l, r), "R3 R5 fill");
    end
    // last call above came at the top level: overflow, level held, window 7 intact
    chk_window("R6 R9 top window kept");
    step(1, 0, 0, 0, '0, "R6 second call at top");
    step(0, 0, 0, 0, '0, "R6 flag drops");
    step(1, 1, 0, 0, '0, "R8 clash at top");
    chk_window("R8 window unchanged");

    // unwind, checking every window survived (R4, R9)
    for (int l = NW - 1; l > 0; l--) begin
      chk_window("R4 R9 unwind");
      if (l == 3) begin
        // write together with a return lands in the window being left (R5)
        step(0, 1, 1, 0, 32'hDEAD0003, "R5 write with ret");
        step(1, 0, 0, 0, '0, "R3 re-enter");
        chk_window("R5 write seen in left window");
        step(0, 1, 0, 0, '0, "R4 leave again");
      end else begin
        step(0, 1, 0, 0, '0, "R4 return");
      end
    end
    chk_window("R4 root window");
    step(0, 1, 0, 0, '0, "R7 return at root");
    step(0, 0, 0, 0, '0, "R7 flag drops");
    step(1, 1, 0, 0, '0, "R8 clash at root");
    // R2: reads follow a write in the next cycle only through the current window
    step(0, 0, 1, 5, 32'h13572468, "R2 R9 root write");
    chk_window("R2 root readback");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule